// File: doc/BRIEF.md
# Addressed Serial Word Node

This block connects one node to a synchronous serial link that up to four nodes share. Each word on the link is 16 bits long. It holds a data byte, the 2-bit number of the node that sent it, the 2-bit number of the node it is meant for, and a 4-bit opcode that says how the byte should be read. A word is marked by a one-cycle frame-sync pulse. The bits follow on the next 16 clock cycles, one per cycle, most significant bit first.

Local logic asks for a transfer by giving a destination, an opcode and a data byte together with a start strobe. The node adds its own number as the sender, sends the sync pulse and then shifts the word out. In the other direction, the node shifts in every framed word. It keeps a word only when the destination field equals the node's own number. A kept word is handed to local logic as data, sender and opcode with a one-cycle valid strobe. A word for any other node is dropped without a trace.

The link runs on the block clock: one bit per cycle. Arbitration between senders, error detection and transactions that span several words are left to the surrounding logic.

Top module: `sxw_node`

## Requirements
- R1: The word layout is opcode in bits 15:12, destination in bits 11:10, sender in bits 9:8 and data byte in bits 7:0. Bits are moved most significant first.
- R2: When the transmitter is idle, a start strobe sampled at a clock edge is accepted. In the cycle that follows, `ser_fs_o` is high for exactly one cycle. On each of the next 16 cycles `ser_d_o` carries one word bit, bit 15 first. The sender field of that word is `my_id`.
- R3: `tx_busy` is high for exactly 17 cycles: from the cycle after the accepting edge through the cycle that carries bit 0. A start strobe seen while `tx_busy` is high is ignored and does not change the word being sent.
- R4: While the transmitter is idle, `ser_fs_o` and `ser_d_o` are both low.
- R5: An edge that samples `ser_fs_i` high starts a word. The next 16 edges sample `ser_d_i` as bits 15 down to 0.
- R6: If the destination field of a received word equals `my_id`, then `rx_valid` is high for exactly one cycle, the cycle after the edge that sampled bit 0. In that cycle `rx_data`, `rx_src` and `rx_op` hold the word's fields.
- R7: A received word whose destination field differs from `my_id` raises no `rx_valid`. It leaves `rx_data`, `rx_src` and `rx_op` unchanged.
- R8: A frame-sync sampled while a word is still being received throws the partial word away and starts a new word.
- R9: After reset, `tx_busy`, `ser_fs_o`, `ser_d_o` and `rx_valid` are low, and the received fields are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and link clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 2 | Number of this node on the link |
| tx_start | input | 1 | Request to send one word |
| tx_dest | input | 2 | Destination node of the word to send |
| tx_op | input | 4 | Opcode of the word to send |
| tx_data | input | 8 | Data byte of the word to send |
| tx_busy | output | 1 | Transmitter is sending a word |
| ser_fs_o | output | 1 | Outgoing frame-sync pulse |
| ser_d_o | output | 1 | Outgoing serial data |
| ser_fs_i | input | 1 | Incoming frame-sync pulse |
| ser_d_i | input | 1 | Incoming serial data |
| rx_valid | output | 1 | One-cycle strobe for an accepted word |
| rx_data | output | 8 | Data byte of the last accepted word |
| rx_src | output | 2 | Sender of the last accepted word |
| rx_op | output | 4 | Opcode of the last accepted word |

## Verification
The assertions check, on every cycle, the shape of the transmit side and the single-cycle valid strobe. On the transmit side that means the one-cycle sync pulse, the exact 17-cycle busy window, a quiet line while idle, and start strobes ignored while busy. On the receive side they also check that the held fields change only together with the strobe. Only the bench scenarios can show that the bits on the line match the packed fields and that the destination filter works for every pairing of node number and destination. They also cover a sync pulse arriving in the middle of a word, which must throw the partial word away.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
  localparam int SXW_DATA_W = 8;
  localparam int SXW_ID_W   = 2;
  localparam int SXW_OP_W   = 4;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_BITS = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/sxw_tx.sv
module sxw_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              fs_o,
  output logic              d_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      fs_o  <= 1'b0;
      d_o   <= 1'b0;
      left  <= '0;
      shreg <= '0;
    end else if (!busy) begin
      d_o <= 1'b0;
      if (start) begin
        shreg <= word;
        fs_o  <= 1'b1;
        busy  <= 1'b1;
        left  <= CNT_W'(WORD_W);
      end
    end else if (left != '0) begin
      fs_o  <= 1'b0;
      d_o   <= shreg[WORD_W-1];
      shreg <= shreg << 1;
      left  <= left - CNT_W'(1);
    end else begin
      busy <= 1'b0;
      fs_o <= 1'b0;
      d_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sxw_rx.sv
module sxw_rx #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   my_id,
  input  logic              fs_i,
  input  logic              d_i,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [ID_W-1:0]   src,
  output logic [OP_W-1:0]   op
);
  localparam int WORD_W = DATA_W + 2 * ID_W + OP_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int SRC_LO = DATA_W;
  localparam int DST_LO = DATA_W + ID_W;
  localparam int OP_LO  = DATA_W + 2 * ID_W;

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] full;

  assign full = {shreg[WORD_W-2:0], d_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      src   <= '0;
      op    <= '0;
      left  <= '0;
      shreg <= '0;
    end else begin
      valid <= 1'b0;
      if (fs_i) begin
        left <= CNT_W'(WORD_W);
      end else if (left != '0) begin
        shreg <= full;
        left  <= left - CNT_W'(1);
        if (left == CNT_W'(1) && full[DST_LO +: ID_W] == my_id) begin
          valid <= 1'b1;
          data  <= full[0 +: DATA_W];
          src   <= full[SRC_LO +: ID_W];
          op    <= full[OP_LO +: OP_W];
        end
      end
    end
  end
endmodule

// File: rtl/sxw_node.sv
module sxw_node #(
  parameter int DATA_W = sxw_pkg::SXW_DATA_W,
  parameter int ID_W   = sxw_pkg::SXW_ID_W,
  parameter int OP_W   = sxw_pkg::SXW_OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   my_id,
  input  logic              tx_start,
  input  logic [ID_W-1:0]   tx_dest,
  input  logic [OP_W-1:0]   tx_op,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              ser_fs_o,
  output logic              ser_d_o,
  input  logic              ser_fs_i,
  input  logic              ser_d_i,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic [ID_W-1:0]   rx_src,
  output logic [OP_W-1:0]   rx_op
);
  localparam int WORD_W = DATA_W + 2 * ID_W + OP_W;

  logic [WORD_W-1:0] tx_word;

  // packing order: opcode, destination, sender, data (high to low)
  assign tx_word = {tx_op, tx_dest, my_id, tx_data};

  sxw_tx #(.WORD_W(WORD_W)) tx_i (
    .clk   (clk),
    .rst   (rst),
    .start (tx_start),
    .word  (tx_word),
    .busy  (tx_busy),
    .fs_o  (ser_fs_o),
    .d_o   (ser_d_o)
  );

  sxw_rx #(.DATA_W(DATA_W), .ID_W(ID_W), .OP_W(OP_W)) rx_i (
    .clk   (clk),
    .rst   (rst),
    .my_id (my_id),
    .fs_i  (ser_fs_i),
    .d_i   (ser_d_i),
    .valid (rx_valid),
    .data  (rx_data),
    .src   (rx_src),
    .op    (rx_op)
  );
endmodule

// File: rtl/sxw_node_chk.sv
module sxw_node_chk #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int OP_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_start,
  input logic              tx_busy,
  input logic              ser_fs_o,
  input logic              ser_d_o,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [ID_W-1:0]   rx_src,
  input logic [OP_W-1:0]   rx_op
);
  localparam int WORD_W = DATA_W + 2 * ID_W + OP_W;
  localparam int LEN_W  = $clog2(WORD_W + 3);

  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)          busy_len <= '0;
    else if (tx_busy) busy_len <= busy_len + LEN_W'(1);
    else              busy_len <= '0;
  end

  AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ser_fs_o |=> !ser_fs_o); // R2

  AST_FS_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    ser_fs_o |-> tx_busy); // R3

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> busy_len == LEN_W'(WORD_W + 1)); // R3

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && tx_start) |=> !ser_fs_o); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> (!ser_fs_o && !ser_d_o)); // R4

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R6

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_src) && $stable(rx_op))); // R7
endmodule

bind sxw_node sxw_node_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .OP_W(OP_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tx_start (tx_start),
  .tx_busy  (tx_busy),
  .ser_fs_o (ser_fs_o),
  .ser_d_o  (ser_d_o),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .rx_src   (rx_src),
  .rx_op    (rx_op)
);

// File: tb/sxw_node_tb.sv
`timescale 1ns/1ps
module sxw_node_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] my_id = 2'd0;
  logic       tx_start = 1'b0;
  logic [1:0] tx_dest = 2'd0;
  logic [3:0] tx_op = 4'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_busy, ser_fs_o, ser_d_o;
  logic       ser_fs_i = 1'b0;
  logic       ser_d_i = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic [1:0] rx_src;
  logic [3:0] rx_op;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sxw_node dut_i (
    .clk(clk), .rst(rst), .my_id(my_id),
    .tx_start(tx_start), .tx_dest(tx_dest), .tx_op(tx_op), .tx_data(tx_data),
    .tx_busy(tx_busy), .ser_fs_o(ser_fs_o), .ser_d_o(ser_d_o),
    .ser_fs_i(ser_fs_i), .ser_d_i(ser_d_i),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_src(rx_src), .rx_op(rx_op)
  );

  always @(negedge clk) if (!rst && rx_valid) vcnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pack(input int op, input int dst, input int src, input int dat);
    return 16'(op * 4096 + dst * 1024 + src * 256 + dat);
  endfunction

  // send nbits of word on the input link after a sync pulse
  task automatic drive_rx(input logic [15:0] w, input int nbits);
    @(negedge clk); ser_fs_i = 1'b1; ser_d_i = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); ser_fs_i = 1'b0; ser_d_i = w[15 - i];
    end
  endtask

  // full transmit with bit-by-bit check; optional start strobe mid-word
  task automatic do_tx(input int dst, input int op, input int dat, input bit poke);
    logic [15:0] w;
    w = pack(op, dst, my_id, dat);
    @(negedge clk);
    tx_dest = 2'(dst); tx_op = 4'(op); tx_data = 8'(dat); tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk(ser_fs_o == 1'b1, "R2 sync", int'(ser_fs_o), 1);
    chk(tx_busy == 1'b1, "R3 busy at sync", int'(tx_busy), 1);
    for (int i = 15; i >= 0; i--) begin
      if (poke && i == 10) begin
        tx_start = 1'b1; tx_op = ~tx_op; tx_data = ~tx_data;
      end else tx_start = 1'b0;
      @(negedge clk);
      chk(ser_d_o == w[i] && ser_fs_o == 1'b0, "R1 R2 bit", int'(ser_d_o), int'(w[i]));
      chk(tx_busy == 1'b1, "R3 busy during bits", int'(tx_busy), 1);
    end
    tx_start = 1'b0;
    @(negedge clk);
    chk(tx_busy == 1'b0, "R3 busy end", int'(tx_busy), 0);
    chk(ser_fs_o == 1'b0 && ser_d_o == 1'b0, "R4 idle line", int'({ser_fs_o, ser_d_o}), 0);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(tx_busy == 0 && ser_fs_o == 0 && ser_d_o == 0, "R9 tx reset", int'({tx_busy, ser_fs_o, ser_d_o}), 0);
    chk(rx_valid == 0 && rx_data == 0 && rx_src == 0 && rx_op == 0, "R9 rx reset", int'(rx_data), 0);
    chk(ser_fs_o == 0 && ser_d_o == 0, "R4 idle after reset", int'({ser_fs_o, ser_d_o}), 0);

    // transmit sweep: R1 R2 R3 R4
    for (int id = 0; id < 4; id++) begin
      my_id = 2'(id);
      for (int dst = 0; dst < 4; dst++)
        for (int op = 0; op < 16; op += 5)
          do_tx(dst, op, (id * 71 + dst * 13 + op * 29) & 255, 1'b0);
    end
    // R3 start strobe while busy is ignored
    my_id = 2'd2;
    do_tx(1, 9, 8'hA5, 1'b1);
    repeat (2) @(negedge clk);
    chk(tx_busy == 0, "R3 ignored start left no transfer", int'(tx_busy), 0);

    // receive sweep: R5 R6 R7
    for (int id = 0; id < 4; id++) begin
      my_id = 2'(id);
      for (int dst = 0; dst < 4; dst++)
        for (int op = 0; op < 16; op++) begin
          int dat, src;
          logic [7:0] pd; logic [1:0] ps; logic [3:0] po;
          dat = (id * 53 + dst * 17 + op * 37 + 5) & 255;
          src = (op + dst) & 3;
          pd = rx_data; ps = rx_src; po = rx_op;
          drive_rx(pack(op, dst, src, dat), 16);
          @(negedge clk); ser_d_i = 1'b0;
          if (dst == id) begin
            chk(rx_valid == 1, "R6 valid on match", int'(rx_valid), 1);
            chk(rx_data == 8'(dat) && rx_src == 2'(src) && rx_op == 4'(op),
                "R1 R6 fields", int'({rx_op, rx_src, rx_data}), int'({4'(op), 2'(src), 8'(dat)}));
          end else begin
            chk(rx_valid == 0, "R7 no valid on mismatch", int'(rx_valid), 0);
            chk(rx_data == pd && rx_src == ps && rx_op == po,
                "R7 fields unchanged", int'({rx_op, rx_src, rx_data}), int'({po, ps, pd}));
          end
          @(negedge clk);
          chk(rx_valid == 0, "R6 valid one cycle", int'(rx_valid), 0);
        end
    end

    // R8 sync mid-word restarts reception
    my_id = 2'd1;
    v0 = vcnt;
    drive_rx(pack(3, 1, 0, 8'h11), 7);
    drive_rx(pack(12, 1, 3, 8'hC4), 16);
    @(negedge clk); ser_d_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(vcnt - v0 == 1, "R8 one word after restart", vcnt - v0, 1);
    chk(rx_data == 8'hC4 && rx_src == 2'd3 && rx_op == 4'd12, "R8 second word kept",
        int'({rx_op, rx_src, rx_data}), int'({4'd12, 2'd3, 8'hC4}));
    v0 = vcnt;
    drive_rx(pack(5, 1, 2, 8'h3C), 12);
    drive_rx(pack(6, 0, 2, 8'h77), 16);
    @(negedge clk); ser_d_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(vcnt - v0 == 0, "R8 partial word discarded", vcnt - v0, 0);
    chk(rx_data == 8'hC4, "R8 fields untouched by partial", int'(rx_data), 8'hC4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule